// File: doc/BRIEF.md
# Configurable Register Macrocell

This block is one storage cell of a programmable logic fabric. It combines a wide logic sum, or a direct input taken from the pad side, with one product term through an optional XOR. The result goes into a storage element that can act as a D flip-flop, a T flip-flop or a level-sensitive latch. Each cell picks its own capture clock from eight sources and its clock enable from four. Set and reset come from a block-wide initialization term and from the cell's own terms. One option exchanges set and reset, and the same option fixes the state the cell takes at power-up.

All behaviour runs in a single system clock domain, `clk_i`. The eight clock sources are treated as ordinary signals and sampled on every `clk_i` edge. A source "rises" on the first `clk_i` edge at which it is seen high after being seen low. `rst_ni` is the power-up initialization. The selected sources are assumed quiet while it is low. A bypass option routes the XOR output straight to the result, without going through the storage element.

Top module: `mcell_top`

## Requirements
- R1: While `rst_ni` is low the result is 0 when `cfg_swap_i` is 0 and 1 when `cfg_swap_i` is 1.
- R2: In D mode (`cfg_mode_i` 0, with 3 behaving the same) the cell captures the data on the `clk_i` edge at which the selected source is first seen high. The value shows on `result_o` after that edge and is held while the source stays high or low.
- R3: Clock select codes are 0..3 for block clocks 0..3, 4 for `pt_clk_i`, 5 for inverted `pt_clk_i`, 6 for the shared clock after its optional inversion, and 7 for ground, which never captures. Clocks that are not selected have no effect.
- R4: Enable select codes are 0 for `pt_init_ce_i`, 1 for its inverse, 2 for the shared clock after its optional inversion (`cfg_shr_clk_inv_i`), and 3 for constant high. The cell does not capture while the enable is low.
- R5: The data is the source XORed with `single_pt_i` when `cfg_xor_en_i` is 1, and the plain source otherwise.
- R6: When `cfg_direct_i` is 1 the source is `direct_i`. Otherwise it is `sum_i`.
- R7: In T mode (`cfg_mode_i` 1) a capture inverts the stored value when the data is 1 and keeps it when the data is 0.
- R8: In latch mode (`cfg_mode_i` 2) the stored value follows the data, one `clk_i` later, while the selected source is high and enabled. It holds while the source is low.
- R9: Block initialization and `pt_init_i` clear the cell. `pt_init_ce_i` sets it when `cfg_cell_set_en_i` is 1. With `cfg_swap_i` set, set and clear trade places. Either takes effect on the next `clk_i` edge whatever the selected clock does. Clear wins over set, and both win over a capture.
- R10: With `cfg_blk_init_inv_i` set, block initialization is active when `blk_init_i` is low.
- R11: With `cfg_bypass_i` set, `result_o` shows the XOR output combinationally. The stored value is kept and reappears when bypass is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all sources are sampled on its rising edge |
| rst_ni | input | 1 | Active-low power-up initialization |
| blk_clk_i | input | 4 | Block clocks 0..3 |
| shr_clk_i | input | 1 | Shared clock term |
| pt_clk_i | input | 1 | Individual clock term |
| pt_init_ce_i | input | 1 | Individual initialization / enable term |
| pt_init_i | input | 1 | Individual initialization term |
| blk_init_i | input | 1 | Block-level initialization term |
| sum_i | input | 1 | Logic sum from the allocator |
| single_pt_i | input | 1 | Single product term for the XOR |
| direct_i | input | 1 | Direct input from the pad side |
| cfg_clk_sel_i | input | 3 | Clock source select |
| cfg_ce_sel_i | input | 2 | Clock enable source select |
| cfg_mode_i | input | 2 | Storage mode: 0 D, 1 T, 2 latch, 3 D |
| cfg_xor_en_i | input | 1 | Enable XOR with the single term |
| cfg_direct_i | input | 1 | Use direct input as data source |
| cfg_bypass_i | input | 1 | Drive result from XOR output |
| cfg_shr_clk_inv_i | input | 1 | Invert shared clock term |
| cfg_blk_init_inv_i | input | 1 | Invert block initialization term |
| cfg_cell_set_en_i | input | 1 | Use `pt_init_ce_i` as cell set |
| cfg_swap_i | input | 1 | Exchange set and reset, power up set |
| result_o | output | 1 | Registered or combinational result |

## Verification
A corrupted stored bit cannot stay hidden for long. In every mode except bypass it drives `result_o` directly, so a wrong capture, a lost toggle or a missed clear shows on the cycle right after the `clk_i` edge that caused it. A wrong edge-detect history is different. It shows only when the selected source next rises, as an extra or missing capture. Because of that, each source is checked across a full low-high-low pulse. Data is always chosen to differ from the stored value, so a capture that should not happen can be seen.

// File: rtl/mcell_pkg.sv
package mcell_pkg;
  localparam int unsigned BLK_CLKS  = 4;
  localparam int unsigned CK_SEL_W  = 3;
  localparam int unsigned CE_SEL_W  = 2;
  localparam int unsigned MODE_W    = 2;
  localparam int unsigned CK_SRCS   = 2 ** CK_SEL_W;
  localparam int unsigned CE_SRCS   = 2 ** CE_SEL_W;

  typedef enum logic [CK_SEL_W-1:0] {
    CK_BLK0   = 3'd0,
    CK_BLK1   = 3'd1,
    CK_BLK2   = 3'd2,
    CK_BLK3   = 3'd3,
    CK_TERM   = 3'd4,
    CK_TERM_N = 3'd5,
    CK_SHARED = 3'd6,
    CK_GND    = 3'd7
  } clk_src_e;

  typedef enum logic [CE_SEL_W-1:0] {
    CE_TERM   = 2'd0,
    CE_TERM_N = 2'd1,
    CE_SHARED = 2'd2,
    CE_ONE    = 2'd3
  } ce_src_e;

  typedef enum logic [MODE_W-1:0] {
    ST_D     = 2'd0,
    ST_T     = 2'd1,
    ST_LATCH = 2'd2,
    ST_D_ALT = 2'd3
  } store_e;
endpackage

// File: rtl/mcell_clk_sel.sv
module mcell_clk_sel
  import mcell_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [BLK_CLKS-1:0] blk_clk_i,
  input  logic                term_clk_i,
  input  logic                shr_clk_i,
  input  clk_src_e            sel_i,
  output logic                level_o,
  output logic                rise_o
);
  logic [CK_SRCS-1:0] src_vec;
  logic               level_q;

  for (genvar g = 0; g < BLK_CLKS; g++) begin : g_blk
    assign src_vec[g] = blk_clk_i[g];
  end
  assign src_vec[CK_TERM]   = term_clk_i;
  assign src_vec[CK_TERM_N] = ~term_clk_i;
  assign src_vec[CK_SHARED] = shr_clk_i;
  assign src_vec[CK_GND]    = 1'b0;

  assign level_o = src_vec[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= 1'b0;
    else         level_q <= level_o;
  end

  assign rise_o = level_o & ~level_q;

  // R3
  gnd_no_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == CK_GND) |-> !rise_o);

  // R2
  edge_needs_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o && $stable(sel_i)) |-> !$past(level_o));
endmodule

// File: rtl/mcell_ce_sel.sv
module mcell_ce_sel
  import mcell_pkg::*;
(
  input  logic    term_ce_i,
  input  logic    shr_clk_i,
  input  ce_src_e sel_i,
  output logic    ce_o
);
  logic [CE_SRCS-1:0] src_vec;

  assign src_vec[CE_TERM]   = term_ce_i;
  assign src_vec[CE_TERM_N] = ~term_ce_i;
  assign src_vec[CE_SHARED] = shr_clk_i;
  assign src_vec[CE_ONE]    = 1'b1;

  assign ce_o = src_vec[sel_i];
endmodule

// File: rtl/mcell_init_ctl.sv
module mcell_init_ctl (
  input  logic blk_init_i,
  input  logic blk_init_inv_i,
  input  logic cell_clr_i,
  input  logic cell_set_i,
  input  logic cell_set_en_i,
  input  logic swap_i,
  output logic set_o,
  output logic clr_o
);
  logic blk_act;
  logic raw_clr;
  logic raw_set;

  assign blk_act = blk_init_i ^ blk_init_inv_i;
  assign raw_clr = blk_act | cell_clr_i;
  assign raw_set = cell_set_i & cell_set_en_i;

  // swap exchanges the meaning of every init source
  always_comb begin
    if (swap_i) begin
      set_o = raw_clr;
      clr_o = raw_set;
    end else begin
      set_o = raw_set;
      clr_o = raw_clr;
    end
  end
endmodule

// File: rtl/mcell_store.sv
module mcell_store
  import mcell_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   por_val_i,
  input  store_e mode_i,
  input  logic   d_i,
  input  logic   rise_i,
  input  logic   level_i,
  input  logic   ce_i,
  input  logic   set_i,
  input  logic   clr_i,
  output logic   q_o
);
  logic q_q;
  logic cap;

  assign cap = rise_i & ce_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= por_val_i;
    end else if (clr_i) begin
      q_q <= 1'b0;
    end else if (set_i) begin
      q_q <= 1'b1;
    end else begin
      unique case (mode_i)
        ST_T:     if (cap && d_i)       q_q <= ~q_q;
        ST_LATCH: if (level_i && ce_i)  q_q <= d_i;
        default:  if (cap)              q_q <= d_i;
      endcase
    end
  end

  assign q_o = q_q;

  // R9
  clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !q_o);

  // R9
  set_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> q_o);

  // R2
  d_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == ST_D) && !(rise_i && ce_i) && !set_i && !clr_i) |=> $stable(q_o));

  // R7
  t_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == ST_T) && rise_i && ce_i && d_i && !set_i && !clr_i)
      |=> (q_o != $past(q_o)));

  // R8
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == ST_LATCH) && !level_i && !set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/mcell_top.sv
module mcell_top
  import mcell_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [BLK_CLKS-1:0] blk_clk_i,
  input  logic                shr_clk_i,
  input  logic                pt_clk_i,
  input  logic                pt_init_ce_i,
  input  logic                pt_init_i,
  input  logic                blk_init_i,
  input  logic                sum_i,
  input  logic                single_pt_i,
  input  logic                direct_i,
  input  logic [CK_SEL_W-1:0] cfg_clk_sel_i,
  input  logic [CE_SEL_W-1:0] cfg_ce_sel_i,
  input  logic [MODE_W-1:0]   cfg_mode_i,
  input  logic                cfg_xor_en_i,
  input  logic                cfg_direct_i,
  input  logic                cfg_bypass_i,
  input  logic                cfg_shr_clk_inv_i,
  input  logic                cfg_blk_init_inv_i,
  input  logic                cfg_cell_set_en_i,
  input  logic                cfg_swap_i,
  output logic                result_o
);
  logic shr_clk;
  logic src;
  logic d;
  logic level;
  logic rise;
  logic ce;
  logic set;
  logic clr;
  logic q;

  assign shr_clk = shr_clk_i ^ cfg_shr_clk_inv_i;
  assign src     = cfg_direct_i ? direct_i : sum_i;
  assign d       = src ^ (cfg_xor_en_i & single_pt_i);

  mcell_clk_sel i_clk_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .blk_clk_i  (blk_clk_i),
    .term_clk_i (pt_clk_i),
    .shr_clk_i  (shr_clk),
    .sel_i      (clk_src_e'(cfg_clk_sel_i)),
    .level_o    (level),
    .rise_o     (rise)
  );

  mcell_ce_sel i_ce_sel (
    .term_ce_i (pt_init_ce_i),
    .shr_clk_i (shr_clk),
    .sel_i     (ce_src_e'(cfg_ce_sel_i)),
    .ce_o      (ce)
  );

  mcell_init_ctl i_init_ctl (
    .blk_init_i     (blk_init_i),
    .blk_init_inv_i (cfg_blk_init_inv_i),
    .cell_clr_i     (pt_init_i),
    .cell_set_i     (pt_init_ce_i),
    .cell_set_en_i  (cfg_cell_set_en_i),
    .swap_i         (cfg_swap_i),
    .set_o          (set),
    .clr_o          (clr)
  );

  mcell_store i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .por_val_i (cfg_swap_i),
    .mode_i    (store_e'(cfg_mode_i)),
    .d_i       (d),
    .rise_i    (rise),
    .level_i   (level),
    .ce_i      (ce),
    .set_i     (set),
    .clr_i     (clr),
    .q_o       (q)
  );

  assign result_o = cfg_bypass_i ? d : q;

  // R11
  bypass_keeps_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_bypass_i && !set && !clr && !rise && !level) |=> $stable(q));
endmodule

// File: tb/test_mcell_top.sv
module test_mcell_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] blk_clk = '0;
  logic       shr_clk = 0, pt_clk = 0, pt_init_ce = 0, pt_init = 0, blk_init = 0;
  logic       sum = 0, single_pt = 0, direct = 0;
  logic [2:0] cfg_clk_sel = '0;
  logic [1:0] cfg_ce_sel = 2'd3;
  logic [1:0] cfg_mode = '0;
  logic       cfg_xor_en = 0, cfg_direct = 0, cfg_bypass = 0, cfg_shr_clk_inv = 0;
  logic       cfg_blk_init_inv = 0, cfg_cell_set_en = 0, cfg_swap = 0;
  logic       result;

  typedef struct {
    logic  v;
    string tag;
  } item_t;
  item_t sb[$];

  int   total = 0;
  int   bad = 0;
  bit   done = 0;
  int   csel = 0;
  logic m = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcell_top i_mcell_top (
    .clk_i              (clk),
    .rst_ni             (rst_ni),
    .blk_clk_i          (blk_clk),
    .shr_clk_i          (shr_clk),
    .pt_clk_i           (pt_clk),
    .pt_init_ce_i       (pt_init_ce),
    .pt_init_i          (pt_init),
    .blk_init_i         (blk_init),
    .sum_i              (sum),
    .single_pt_i        (single_pt),
    .direct_i           (direct),
    .cfg_clk_sel_i      (cfg_clk_sel),
    .cfg_ce_sel_i       (cfg_ce_sel),
    .cfg_mode_i         (cfg_mode),
    .cfg_xor_en_i       (cfg_xor_en),
    .cfg_direct_i       (cfg_direct),
    .cfg_bypass_i       (cfg_bypass),
    .cfg_shr_clk_inv_i  (cfg_shr_clk_inv),
    .cfg_blk_init_inv_i (cfg_blk_init_inv),
    .cfg_cell_set_en_i  (cfg_cell_set_en),
    .cfg_swap_i         (cfg_swap),
    .result_o           (result)
  );

  // monitor: compare queued expectations a quarter period after each edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        total++;
        if (result !== it.v) begin
          bad++;
          $display("FAIL %s: result_o=%b expected=%b at %0t", it.tag, result, it.v, $time);
        end
      end
    end
  end

  task automatic at_neg();
    @(negedge clk);
  endtask

  task automatic chk(input logic e, input string tag);
    sb.push_back('{e, tag});
  endtask

  task automatic idle(input string tag);
    at_neg();
    chk(m, tag);
  endtask

  task automatic set_src(input int sel, input logic v);
    case (sel)
      0, 1, 2, 3: blk_clk[sel] = v;
      4:          pt_clk = v;
      5:          pt_clk = ~v;
      6:          shr_clk = v ^ cfg_shr_clk_inv;
      default:    ;
    endcase
  endtask

  // full low-high-low pulse of the selected source
  task automatic cap(input logic e, input string tag);
    at_neg();
    set_src(csel, 1'b1);
    chk(e, tag);
    at_neg();
    set_src(csel, 1'b0);
    chk(e, tag);
    m = e;
  endtask

  initial begin
    // R1 power-up value follows swap
    at_neg(); chk(1'b0, "R1");
    at_neg(); cfg_swap = 1; chk(1'b1, "R1");
    at_neg(); cfg_swap = 0; chk(1'b0, "R1");
    at_neg(); rst_ni = 1; chk(1'b0, "R2");
    m = 0;

    // R2 D capture and hold
    at_neg(); sum = 1; chk(1'b0, "R2");
    cap(1'b1, "R2");
    at_neg(); sum = 0; blk_clk[0] = 1; chk(1'b0, "R2");
    at_neg(); sum = 1; chk(1'b0, "R2");
    at_neg(); blk_clk[0] = 0; chk(1'b0, "R2");
    m = 0;
    at_neg(); cfg_mode = 2'd3; chk(1'b0, "R2");
    cap(1'b1, "R2");
    cfg_mode = 2'd0;

    // R3 every clock source
    for (int s = 1; s <= 6; s++) begin
      at_neg();
      cfg_clk_sel = 3'(s);
      csel = s;
      set_src(s, 1'b0);
      sum = ~m;
      chk(m, "R3");
      cap(~m, "R3");
    end
    at_neg(); sum = ~m; blk_clk[0] = 1; chk(m, "R3");
    at_neg(); blk_clk[0] = 0; chk(m, "R3");
    at_neg(); cfg_clk_sel = 3'd7; csel = 7; chk(m, "R3");
    at_neg(); blk_clk = 4'hF; pt_clk = 0; shr_clk = 1; chk(m, "R3");
    at_neg(); blk_clk = 4'h0; pt_clk = 1; shr_clk = 0; chk(m, "R3");
    at_neg(); pt_clk = 0; chk(m, "R3");
    at_neg(); cfg_clk_sel = 3'd0; csel = 0; chk(m, "R3");

    // R4 clock enable sources
    cfg_ce_sel = 2'd0; pt_init_ce = 0; sum = ~m;
    cap(m, "R4");
    pt_init_ce = 1;
    cap(~m, "R4");
    cfg_ce_sel = 2'd1; sum = ~m;
    cap(m, "R4");
    pt_init_ce = 0;
    cap(~m, "R4");
    cfg_ce_sel = 2'd2; shr_clk = 0; sum = ~m;
    cap(m, "R4");
    shr_clk = 1;
    cap(~m, "R4");
    cfg_shr_clk_inv = 1; shr_clk = 1; sum = ~m;
    cap(m, "R4");
    shr_clk = 0;
    cap(~m, "R4");
    cfg_shr_clk_inv = 0; shr_clk = 0; cfg_ce_sel = 2'd3;

    // R5 XOR with single term
    cfg_xor_en = 1; sum = 1; single_pt = 1;
    cap(1'b0, "R5");
    sum = 0;
    cap(1'b1, "R5");
    sum = 1; single_pt = 0;
    cap(1'b1, "R5");
    cfg_xor_en = 0; sum = 0; single_pt = 1;
    cap(1'b0, "R5");
    single_pt = 0;

    // R6 direct input
    cfg_direct = 1; direct = 1; sum = 0;
    cap(1'b1, "R6");
    direct = 0; sum = 1;
    cap(1'b0, "R6");
    cfg_direct = 0;

    // R7 toggle mode
    cfg_mode = 2'd1; sum = 1;
    cap(1'b1, "R7");
    cap(1'b0, "R7");
    cap(1'b1, "R7");
    sum = 0;
    cap(1'b1, "R7");
    cfg_mode = 2'd2;

    // R8 latch mode
    at_neg(); sum = 0; chk(1'b1, "R8");
    at_neg(); blk_clk[0] = 1; chk(1'b0, "R8");
    at_neg(); sum = 1; chk(1'b1, "R8");
    at_neg(); sum = 0; chk(1'b0, "R8");
    at_neg(); blk_clk[0] = 0; sum = 1; chk(1'b0, "R8");
    at_neg(); chk(1'b0, "R8");
    at_neg(); cfg_ce_sel = 2'd0; pt_init_ce = 0; blk_clk[0] = 1; chk(1'b0, "R8");
    at_neg(); pt_init_ce = 1; chk(1'b1, "R8");
    at_neg(); blk_clk[0] = 0; pt_init_ce = 0; cfg_ce_sel = 2'd3; chk(1'b1, "R8");
    m = 1;
    cfg_mode = 2'd0; sum = 0;

    // R9 set, clear, priority, swap
    at_neg(); blk_init = 1; chk(1'b0, "R9");
    at_neg(); blk_init = 0; chk(1'b0, "R9");
    sum = 1;
    cap(1'b1, "R9");
    at_neg(); pt_init = 1; chk(1'b0, "R9");
    at_neg(); pt_init = 0; chk(1'b0, "R9");
    cfg_cell_set_en = 1;
    at_neg(); pt_init_ce = 1; chk(1'b1, "R9");
    at_neg(); pt_init = 1; chk(1'b0, "R9");
    at_neg(); pt_init = 0; pt_init_ce = 0; chk(1'b0, "R9");
    sum = 1; pt_init = 1;
    cap(1'b0, "R9");
    pt_init = 0;
    cfg_swap = 1;
    at_neg(); blk_init = 1; chk(1'b1, "R9");
    at_neg(); blk_init = 0; chk(1'b1, "R9");
    at_neg(); pt_init_ce = 1; chk(1'b0, "R9");
    at_neg(); pt_init_ce = 0; pt_init = 1; chk(1'b1, "R9");
    at_neg(); pt_init = 0; cfg_swap = 0; chk(1'b1, "R9");
    m = 1;
    cfg_cell_set_en = 0;

    // R10 inverted block initialization
    at_neg(); cfg_blk_init_inv = 1; chk(1'b0, "R10");
    at_neg(); blk_init = 1; chk(1'b0, "R10");
    sum = 1;
    cap(1'b1, "R10");
    at_neg(); blk_init = 0; chk(1'b0, "R10");
    at_neg(); cfg_blk_init_inv = 0; chk(1'b0, "R10");
    m = 0;

    // R11 bypass
    sum = 1;
    cap(1'b1, "R11");
    at_neg(); cfg_bypass = 1; sum = 0; chk(1'b0, "R11");
    at_neg(); sum = 1; chk(1'b1, "R11");
    at_neg(); sum = 0; cfg_xor_en = 1; single_pt = 1; chk(1'b1, "R11");
    at_neg(); cfg_xor_en = 0; single_pt = 0; cfg_bypass = 0; chk(1'b1, "R11");

    at_neg();
    @(posedge clk);
    #(CLK_PERIOD/2);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule